// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block schedules read data on the device side of a double-data-rate SDRAM. Each clock it takes one decoded command (no-op, read with bank and column, write, or burst stop). Each read and each burst stop is carried through a CAS-latency delay line that counts half-clocks. The block then emits the read burst as a stream of beats. Each clock carries two half-clock lanes: lane 0 is the first half of the clock and lane 1 the second. For every lane the block reports whether a beat is present, its index within the burst, its bank and its column address. It also drives the DQ output enable for that lane. Data is represented by its column address tag; no data array is modelled.

A read that arrives while an earlier burst is still in flight replaces that burst at its own latency. The earlier burst keeps its beats until then, and the new burst runs its full length. A burst stop silences the outputs from its own latency onward. This lets a write follow a read without two sources driving the data bus. A write that comes too soon after a burst stop raises a one-clock protocol-error pulse. The write itself is still accepted.

Top module: `ddr_rd_sequencer`

## Requirements
- R1: While reset is held, and after its release until a command acts, all beat-valid, output-enable and error outputs are low.
- R2: A READ sampled at clock edge e, with latency L half-clocks (cfg_clh_i = 4, 5 or 6 for CL 2, 2.5, 3), puts its first beat in the output after edge e + floor(L/2), in lane L mod 2 (lane 0 = bits [0], first half).
- R3: cfg_bl_i code 1, 2, 3 selects 2, 4, 8 beats. The beats go out in consecutive half-clock slots with beat index 0 up to length-1, and all beats of a burst carry the bank of their READ.
- R4: The beat column is the start column with its low log2(length) bits counting up from the start value and wrapping inside the aligned block; the upper bits stay fixed.
- R5: A READ to any bank during a burst truncates it. Old beats continue up to the new read's first slot, and the new read then sends its full length from its own column and bank.
- R6: READ commands on consecutive clocks are legal and raise no protocol error.
- R7: A BURST STOP (cmd 2'b11) cancels every beat from the half-clock slot at its own CAS latency onward, and the output enable is low from that slot.
- R8: The output enable is high in the half-clock slot before a burst's first beat and during each beat, and it is low in the slot after the last beat.
- R9: A WRITE (cmd 2'b10) sampled fewer than ceil(L/2) clocks after the latest BURST STOP raises perr_o for one clock after that write's edge. At exactly ceil(L/2) clocks, no error is raised.
- R10: WRITE and NOP (cmd 2'b00) commands leave a burst in flight unchanged; READ is cmd 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command: 00 NOP, 01 READ, 10 WRITE, 11 BURST STOP |
| bank_i | input | BANK_W | Bank of a READ |
| col_i | input | COL_W | Start column of a READ |
| cfg_bl_i | input | 2 | Burst length code (1:2, 2:4, 3:8) |
| cfg_clh_i | input | 3 | CAS latency in half-clocks (4, 5, 6) |
| rd_valid_o | output | 2 | Beat present, per lane |
| rd_beat_o | output | 2*BEAT_W | Beat index, per lane |
| rd_col_o | output | 2*COL_W | Beat column address, per lane |
| rd_bank_o | output | 2*BANK_W | Beat bank, per lane |
| dq_oe_o | output | 2 | DQ output enable, per lane |
| perr_o | output | 1 | One-clock protocol-error pulse |

## Verification
A READ or BURST STOP sampled at edge e acts on the outputs registered at edge e + floor(L/2), in lane L mod 2. The preamble output enable appears one half-clock earlier, which for even L is lane 1 of the previous clock. The error pulse is registered at the WRITE's own edge. In each directed scenario, the bench drives commands on falling edges and numbers them by the rising edge that samples them. At the next falling edge it stores the outputs of every clock under the number of the edge that produced them. Each expected beat, enable and error value is then compared at exactly the index these latencies give.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_STOP  = 2'b11
    } cmd_e;

endpackage

// File: rtl/ddrseq_cmd_pipe.sv
module ddrseq_cmd_pipe
    import ddrseq_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int BANK_W  = 2,
    parameter int MAX_CLH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [2:0]        clh_i,
    output logic              tap_vld_o,
    output logic              tap_stop_o,
    output logic              tap_lane_o,
    output logic [BANK_W-1:0] tap_bank_o,
    output logic [COL_W-1:0]  tap_col_o,
    output logic              pre_rd_o
);
    localparam int DEPTH = MAX_CLH / 2;

    typedef struct packed {
        logic              vld;
        logic              stp;
        logic              lane;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } ev_t;

    ev_t pipe_q [DEPTH];
    ev_t pipe_d [DEPTH];
    int  dly;

    always_comb begin
        pipe_d[0].vld  = (cmd_i == CMD_READ) || (cmd_i == CMD_STOP);
        pipe_d[0].stp  = (cmd_i == CMD_STOP);
        pipe_d[0].lane = clh_i[0];
        pipe_d[0].bank = bank_i;
        pipe_d[0].col  = col_i;
        for (int k = 1; k < DEPTH; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                pipe_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                pipe_q[k] <= pipe_d[k];
            end
        end
    end

    // whole-clock part of the latency selects the tap
    always_comb begin
        dly = int'(clh_i >> 1);
        if (dly < 2)     dly = 2;
        if (dly > DEPTH) dly = DEPTH;
        tap_vld_o  = pipe_q[dly-1].vld;
        tap_stop_o = pipe_q[dly-1].stp;
        tap_lane_o = pipe_q[dly-1].lane;
        tap_bank_o = pipe_q[dly-1].bank;
        tap_col_o  = pipe_q[dly-1].col;
        pre_rd_o   = pipe_q[dly-2].vld && !pipe_q[dly-2].stp && !pipe_q[dly-2].lane;
    end

endmodule

// File: rtl/ddrseq_burst_eng.sv
module ddrseq_burst_eng #(
    parameter int COL_W  = 9,
    parameter int BANK_W = 2,
    parameter int BEAT_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  cfg_bl_i,
    input  logic                        ev_vld_i,
    input  logic                        ev_stop_i,
    input  logic                        ev_lane_i,
    input  logic [BANK_W-1:0]           ev_bank_i,
    input  logic [COL_W-1:0]            ev_col_i,
    input  logic                        pre_rd_i,
    output logic [1:0]                  vld_o,
    output logic [1:0][BEAT_W-1:0]      beat_o,
    output logic [1:0][COL_W-1:0]       col_o,
    output logic [1:0][BANK_W-1:0]      bank_o,
    output logic [1:0]                  oe_o
);
    typedef struct packed {
        logic                   act;
        logic [BEAT_W-1:0]      beat;
        logic [COL_W-1:0]       col;
        logic [BANK_W-1:0]      bank;
        logic [1:0]             ovld;
        logic [1:0][BEAT_W-1:0] obeat;
        logic [1:0][COL_W-1:0]  ocol;
        logic [1:0][BANK_W-1:0] obank;
        logic [1:0]             ooe;
    } st_t;

    st_t               st_q, st_d;
    logic [BEAT_W-1:0] bl_last;
    logic [COL_W-1:0]  wrap_mask;

    always_comb begin
        case (cfg_bl_i)
            2'd2:    bl_last = BEAT_W'(3);
            2'd3:    bl_last = BEAT_W'(7);
            default: bl_last = BEAT_W'(1);
        endcase
        wrap_mask = COL_W'(bl_last);
    end

    always_comb begin
        st_d       = st_q;
        st_d.ovld  = '0;
        st_d.obeat = '0;
        st_d.ocol  = '0;
        st_d.obank = '0;
        for (int j = 0; j < 2; j++) begin
            if (ev_vld_i && (ev_lane_i == (j == 1))) begin
                if (ev_stop_i) begin
                    st_d.act = 1'b0;
                end else begin
                    st_d.act  = 1'b1;
                    st_d.beat = '0;
                    st_d.col  = ev_col_i;
                    st_d.bank = ev_bank_i;
                end
            end
            if (st_d.act) begin
                st_d.ovld[j]  = 1'b1;
                st_d.obeat[j] = st_d.beat;
                st_d.ocol[j]  = (st_d.col & ~wrap_mask) |
                                ((st_d.col + COL_W'(st_d.beat)) & wrap_mask);
                st_d.obank[j] = st_d.bank;
                if (st_d.beat == bl_last) begin
                    st_d.act = 1'b0;
                end else begin
                    st_d.beat = st_d.beat + 1'b1;
                end
            end
        end
        // preamble: enable one half-clock ahead of a starting burst
        st_d.ooe[0] = st_d.ovld[0] || (ev_vld_i && !ev_stop_i && ev_lane_i);
        st_d.ooe[1] = st_d.ovld[1] || pre_rd_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.ovld;
    assign beat_o = st_q.obeat;
    assign col_o  = st_q.ocol;
    assign bank_o = st_q.obank;
    assign oe_o   = st_q.ooe;

    assert_beat_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ovld[0] || st_q.obeat[0] <= bl_last) &&
        (!st_q.ovld[1] || st_q.obeat[1] <= bl_last));

    assert_lane_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_vld_i && ev_lane_i) |=>
        (st_q.ovld != 2'b11) || (st_q.obeat[1] == st_q.obeat[0] + 1'b1));

    assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_vld_i && ev_lane_i) |=>
        (st_q.ovld != 2'b11) || (st_q.obank[1] == st_q.obank[0]));

endmodule

// File: rtl/ddrseq_gap_chk.sv
module ddrseq_gap_chk
    import ddrseq_pkg::*;
#(
    parameter int MAX_CLH = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd_i,
    input  logic [2:0] clh_i,
    output logic       perr_o
);
    localparam int CNT_W = $clog2(MAX_CLH / 2 + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] since;
        logic             perr;
    } gap_t;

    gap_t             g_q, g_d;
    logic [CNT_W-1:0] min_gap;

    always_comb begin
        min_gap = CNT_W'((int'(clh_i) + 1) >> 1);
        g_d     = g_q;
        g_d.perr = (cmd_i == CMD_WRITE) && (g_q.since < min_gap);
        if (cmd_i == CMD_STOP)        g_d.since = CNT_W'(1);
        else if (g_q.since != CNT_MAX) g_d.since = g_q.since + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g_q.since <= CNT_MAX;
            g_q.perr  <= 1'b0;
        end else begin
            g_q <= g_d;
        end
    end

    assign perr_o = g_q.perr;

    assert_perr_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> ($past(cmd_i) == CMD_WRITE));

endmodule

// File: rtl/ddr_rd_sequencer.sv
module ddr_rd_sequencer #(
    parameter int COL_W   = 9,
    parameter int BANK_W  = 2,
    parameter int MAX_CLH = 6,
    parameter int MAX_BL  = 8,
    localparam int BEAT_W = $clog2(MAX_BL)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cmd_i,
    input  logic [BANK_W-1:0]     bank_i,
    input  logic [COL_W-1:0]      col_i,
    input  logic [1:0]            cfg_bl_i,
    input  logic [2:0]            cfg_clh_i,
    output logic [1:0]            rd_valid_o,
    output logic [2*BEAT_W-1:0]   rd_beat_o,
    output logic [2*COL_W-1:0]    rd_col_o,
    output logic [2*BANK_W-1:0]   rd_bank_o,
    output logic [1:0]            dq_oe_o,
    output logic                  perr_o
);
    logic              tap_vld, tap_stop, tap_lane, pre_rd;
    logic [BANK_W-1:0] tap_bank;
    logic [COL_W-1:0]  tap_col;

    ddrseq_cmd_pipe #(.COL_W(COL_W), .BANK_W(BANK_W), .MAX_CLH(MAX_CLH)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .col_i(col_i),
        .clh_i(cfg_clh_i), .tap_vld_o(tap_vld), .tap_stop_o(tap_stop),
        .tap_lane_o(tap_lane), .tap_bank_o(tap_bank), .tap_col_o(tap_col),
        .pre_rd_o(pre_rd)
    );

    ddrseq_burst_eng #(.COL_W(COL_W), .BANK_W(BANK_W), .BEAT_W(BEAT_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .cfg_bl_i(cfg_bl_i), .ev_vld_i(tap_vld),
        .ev_stop_i(tap_stop), .ev_lane_i(tap_lane), .ev_bank_i(tap_bank),
        .ev_col_i(tap_col), .pre_rd_i(pre_rd), .vld_o(rd_valid_o),
        .beat_o(rd_beat_o), .col_o(rd_col_o), .bank_o(rd_bank_o), .oe_o(dq_oe_o)
    );

    ddrseq_gap_chk #(.MAX_CLH(MAX_CLH)) u_gap (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .clh_i(cfg_clh_i), .perr_o(perr_o)
    );

endmodule

// File: tb/test_ddr_rd_sequencer.sv
module test_ddr_rd_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W = 9;
    localparam int BANK_W = 2;
    localparam int BEAT_W = 3;
    localparam int NOBS = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cmd_i = 2'b00;
    logic [BANK_W-1:0] bank_i = '0;
    logic [COL_W-1:0] col_i = '0;
    logic [1:0] cfg_bl_i = 2'd2;
    logic [2:0] cfg_clh_i = 3'd6;
    logic [1:0] rd_valid_o;
    logic [2*BEAT_W-1:0] rd_beat_o;
    logic [2*COL_W-1:0] rd_col_o;
    logic [2*BANK_W-1:0] rd_bank_o;
    logic [1:0] dq_oe_o;
    logic perr_o;

    ddr_rd_sequencer #(.COL_W(COL_W), .BANK_W(BANK_W)) i_ddr_rd_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .col_i(col_i),
        .cfg_bl_i(cfg_bl_i), .cfg_clh_i(cfg_clh_i), .rd_valid_o(rd_valid_o),
        .rd_beat_o(rd_beat_o), .rd_col_o(rd_col_o), .rd_bank_o(rd_bank_o),
        .dq_oe_o(dq_oe_o), .perr_o(perr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [1:0]          ov  [NOBS];
    logic [2*BEAT_W-1:0] obt [NOBS];
    logic [2*COL_W-1:0]  oc  [NOBS];
    logic [2*BANK_W-1:0] obk [NOBS];
    logic [1:0]          ooe [NOBS];
    logic                op  [NOBS];
    logic [1:0]          sc  [NOBS];
    logic [BANK_W-1:0]   sb  [NOBS];
    logic [COL_W-1:0]    scl [NOBS];

    task automatic chk(string r, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic clear_sched();
        for (int i = 0; i < NOBS; i++) begin
            sc[i] = 2'b00; sb[i] = '0; scl[i] = '0;
        end
    endtask

    task automatic put(int i, logic [1:0] c, int b, int col);
        sc[i] = c; sb[i] = BANK_W'(b); scl[i] = COL_W'(col);
    endtask

    // command i is sampled by rising edge i; outputs after edge i land in index i
    task automatic run(int n);
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                ov[i-1] = rd_valid_o; obt[i-1] = rd_beat_o; oc[i-1] = rd_col_o;
                obk[i-1] = rd_bank_o; ooe[i-1] = dq_oe_o; op[i-1] = perr_o;
            end
            cmd_i  = (i < n) ? sc[i] : 2'b00;
            bank_i = (i < n) ? sb[i] : '0;
            col_i  = (i < n) ? scl[i] : '0;
        end
        cmd_i = 2'b00;
        repeat (6) @(negedge clk);
    endtask

    task automatic setcfg(logic [1:0] bl, logic [2:0] clh);
        @(negedge clk);
        cfg_bl_i = bl; cfg_clh_i = clh;
        repeat (4) @(negedge clk);
    endtask

    task automatic slot(string r, int cy, int ln, int v, int col, int beat, int bank);
        chk(r, $sformatf("valid c%0d l%0d", cy, ln), int'(ov[cy][ln]), v);
        if (v != 0) begin
            chk(r, $sformatf("col c%0d l%0d", cy, ln), int'(oc[cy][ln*COL_W +: COL_W]), col);
            chk(r, $sformatf("beat c%0d l%0d", cy, ln), int'(obt[cy][ln*BEAT_W +: BEAT_W]), beat);
            chk(r, $sformatf("bank c%0d l%0d", cy, ln), int'(obk[cy][ln*BANK_W +: BANK_W]), bank);
        end
    endtask

    task automatic oe(string r, int cy, int ln, int exp);
        chk(r, $sformatf("oe c%0d l%0d", cy, ln), int'(ooe[cy][ln]), exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "valid in reset", int'(rd_valid_o), 0);
        chk("R1", "oe in reset", int'(dq_oe_o), 0);
        chk("R1", "perr in reset", int'(perr_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "valid after reset", int'(rd_valid_o), 0);
        chk("R1", "oe after reset", int'(dq_oe_o), 0);
    endtask

    task automatic t_basic_cl3_bl4();
        setcfg(2'd2, 3'd6);
        clear_sched(); put(0, 2'b01, 1, 5); run(10);
        slot("R2", 2, 0, 0, 0, 0, 0); slot("R2", 2, 1, 0, 0, 0, 0);
        oe("R8", 2, 0, 0); oe("R8", 2, 1, 1);
        slot("R2", 3, 0, 1, 5, 0, 1); slot("R4", 3, 1, 1, 6, 1, 1);
        slot("R4", 4, 0, 1, 7, 2, 1); slot("R4", 4, 1, 1, 4, 3, 1);
        slot("R3", 5, 0, 0, 0, 0, 0);
        oe("R8", 5, 0, 0); oe("R8", 5, 1, 0);
    endtask

    task automatic t_cl25_bl8();
        setcfg(2'd3, 3'd5);
        clear_sched(); put(0, 2'b01, 3, 3); run(10);
        oe("R8", 1, 1, 0);
        slot("R2", 2, 0, 0, 0, 0, 0); oe("R8", 2, 0, 1);
        slot("R2", 2, 1, 1, 3, 0, 3);
        slot("R3", 3, 0, 1, 4, 1, 3); slot("R3", 3, 1, 1, 5, 2, 3);
        slot("R3", 4, 0, 1, 6, 3, 3); slot("R4", 4, 1, 1, 7, 4, 3);
        slot("R4", 5, 0, 1, 0, 5, 3); slot("R4", 5, 1, 1, 1, 6, 3);
        slot("R4", 6, 0, 1, 2, 7, 3); slot("R3", 6, 1, 0, 0, 0, 0);
        oe("R8", 6, 1, 0);
    endtask

    task automatic t_cl2_bl2();
        setcfg(2'd1, 3'd4);
        clear_sched(); put(0, 2'b01, 0, 9); run(8);
        oe("R8", 1, 0, 0); oe("R8", 1, 1, 1);
        slot("R2", 2, 0, 1, 9, 0, 0); slot("R4", 2, 1, 1, 8, 1, 0);
        slot("R3", 3, 0, 0, 0, 0, 0); oe("R8", 3, 0, 0);
    endtask

    task automatic t_interrupt();
        setcfg(2'd2, 3'd6);
        clear_sched(); put(0, 2'b01, 0, 0); put(1, 2'b01, 2, 16); run(10);
        slot("R5", 3, 0, 1, 0, 0, 0); slot("R5", 3, 1, 1, 1, 1, 0);
        slot("R5", 4, 0, 1, 16, 0, 2); slot("R5", 4, 1, 1, 17, 1, 2);
        slot("R5", 5, 0, 1, 18, 2, 2); slot("R5", 5, 1, 1, 19, 3, 2);
        slot("R5", 6, 0, 0, 0, 0, 0);
        oe("R8", 4, 0, 1);
        for (int i = 0; i < 8; i++) chk("R6", $sformatf("perr c%0d", i), int'(op[i]), 0);
    endtask

    task automatic t_stop_write();
        setcfg(2'd2, 3'd6);
        clear_sched(); put(0, 2'b01, 1, 8); put(1, 2'b11, 0, 0); put(4, 2'b10, 0, 0); run(10);
        slot("R7", 3, 0, 1, 8, 0, 1); slot("R7", 3, 1, 1, 9, 1, 1);
        slot("R7", 4, 0, 0, 0, 0, 0); slot("R7", 4, 1, 0, 0, 0, 0);
        oe("R7", 4, 0, 0); oe("R7", 4, 1, 0);
        chk("R9", "perr at legal gap", int'(op[4]), 0);
    endtask

    task automatic t_gap_err();
        setcfg(2'd2, 3'd6);
        clear_sched(); put(0, 2'b11, 0, 0); put(2, 2'b10, 0, 0); run(8);
        chk("R9", "perr before write", int'(op[1]), 0);
        chk("R9", "perr short gap cl3", int'(op[2]), 1);
        chk("R9", "perr one clock only", int'(op[3]), 0);
        setcfg(2'd2, 3'd4);
        clear_sched(); put(0, 2'b11, 0, 0); put(1, 2'b10, 0, 0); put(2, 2'b10, 0, 0); run(8);
        chk("R9", "perr short gap cl2", int'(op[1]), 1);
        chk("R9", "perr exact gap cl2", int'(op[2]), 0);
    endtask

    task automatic t_write_ignored();
        setcfg(2'd2, 3'd6);
        clear_sched(); put(0, 2'b01, 1, 12); put(2, 2'b10, 0, 0); run(10);
        slot("R10", 3, 0, 1, 12, 0, 1); slot("R10", 3, 1, 1, 13, 1, 1);
        slot("R10", 4, 0, 1, 14, 2, 1); slot("R10", 4, 1, 1, 15, 3, 1);
        chk("R10", "perr write without stop", int'(op[2]), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_basic_cl3_bl4();
        t_cl25_bl8();
        t_cl2_bl2();
        t_interrupt();
        t_stop_write();
        t_gap_err();
        t_write_ignored();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule